// File: doc/BRIEF.md
# Single-to-Brain-Float Narrowing Converter

This block takes a 32-bit single-precision operand and narrows it to a 16-bit brain-float value. The sign, the exponent bias and the exponent range stay the same, and the fraction is cut from 23 bits to 7. The discarded low bits are rounded under one of five rounding modes. The mode comes either from the instruction's rounding-mode field or, when that field holds the dynamic code, from the dynamic rounding-mode register value.

The converter produces the five standard exception flags. It accepts subnormal inputs and produces subnormal results. It handles overflow and returns a single canonical NaN. Underflow uses tininess detected after rounding: a second rounding, done as if the exponent were unbounded, decides whether the value is tiny, separately from the rounding that produces the result.

The block is a single registered stage. A strobe on `in_valid` gives a result, flags and the illegal-mode indication with `out_valid` one clock later.

Top module: `fp32_to_bf16_cvt`

## Requirements
- R1: The result holds the sign in bit 15, the biased exponent (bias 127) in bits 14:7 and the fraction in bits 6:0. For finite non-NaN inputs it is the input correctly rounded to 8 significant bits under the selected mode.
- R2: The mode codes are: 000 nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, and 100 nearest with ties away from zero.
- R3: A rounding-mode field of 111 uses `dyn_rm` as the mode in place of the field.
- R4: The mode is illegal when the field is 101 or 110, or when the field is 111 and `dyn_rm` is above 100. An illegal mode sets `bad_rm` to 1 and forces the result to 0x0000 and the flags to 0.
- R5: Subnormal inputs (exponent field 0) are accepted. A rounded magnitude below 2^-126 is returned as a subnormal, and rounding may carry it up to 0x0080.
- R6: Every NaN result is 0x7FC0. A signalling NaN input (fraction bit 22 clear) sets invalid (flag bit 4). A quiet NaN input sets no flag.
- R7: Overflow sets overflow (flag bit 2) and inexact (flag bit 0). The result is infinity under the two nearest modes and under a directed mode that rounds away from zero for that sign. Otherwise the result is 0x7F7F with the sign applied.
- R8: The value is tiny when its rounding at 8 significant bits, with an unbounded exponent, is below 2^-126. Underflow (flag bit 1) is set only when the value is tiny and inexact.
- R9: Inexact (flag bit 0) is set whenever any of the 16 discarded input bits of a finite operand is nonzero. Divide-by-zero (flag bit 3) is always 0.
- R10: Infinities pass through with their sign and set no flags. Zeros return a zero of the same sign and set no flags.
- R11: `out_valid` is `in_valid` delayed by one clock, and the result, flags and `bad_rm` belong to the operand accepted on that strobe. All outputs are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| op_a | input | 32 | Single-precision operand |
| rm_field | input | 3 | Instruction rounding-mode field |
| dyn_rm | input | 3 | Dynamic rounding-mode register value |
| out_valid | output | 1 | Result strobe |
| result | output | 16 | Brain-float result |
| flags | output | 5 | {invalid, div-by-zero, overflow, underflow, inexact} |
| bad_rm | output | 1 | Illegal rounding mode |

## Verification
The hardest case to reach is a subnormal input whose final rounding carries up to the smallest normal value while its unbounded-exponent rounding stays below 2^-126. Only then does underflow appear on a result that looks normal. Random operands almost never land on such a case, because the fraction must hold all ones in its top eight bits with specific guard bits. The stimulus therefore drives these patterns directly (0x007F8000 and 0x007FFFFF under several modes). On top of that, the random stream is biased toward exponent fields 0, 1, 254 and 255 and toward long runs of ones in the fraction.

// File: rtl/fp32_to_bf16_cvt.sv
module fp32_to_bf16_cvt #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  op_a,
  input  logic [2:0]       rm_field,
  input  logic [2:0]       dyn_rm,
  output logic             out_valid,
  output logic [OUT_W-1:0] result,
  output logic [4:0]       flags,
  output logic             bad_rm
);
  localparam int DROP = IN_W - OUT_W;

  function automatic logic rnd_up(input logic [2:0] m, input logic s,
                                  input logic lsb, input logic g, input logic st);
    case (m)
      3'd0: rnd_up = g & (st | lsb);
      3'd2: rnd_up = s & (g | st);
      3'd3: rnd_up = ~s & (g | st);
      3'd4: rnd_up = g;
      default: rnd_up = 1'b0;
    endcase
  endfunction

  logic [2:0]  mode;
  logic        illegal, sgn, is_nan, is_inf, g, st, inc, nx, ovf, away;
  logic        tiny, inc_unb;
  logic [7:0]  expo;
  logic [22:0] frac;
  logic [15:0] mag;
  logic [15:0] res_c;
  logic [4:0]  flg_c;

  assign mode    = (rm_field == 3'b111) ? dyn_rm : rm_field;
  assign illegal = mode > 3'd4;
  assign sgn     = op_a[31];
  assign expo    = op_a[30:23];
  assign frac    = op_a[22:0];
  assign is_nan  = (expo == 8'hFF) && (frac != '0);
  assign is_inf  = (expo == 8'hFF) && (frac == '0);

  assign g   = op_a[DROP-1];
  assign st  = |op_a[DROP-2:0];
  assign nx  = g | st;
  assign inc = rnd_up(mode, sgn, op_a[DROP], g, st);
  assign mag = {1'b0, op_a[30:DROP]} + {15'd0, inc};
  assign ovf = !is_inf && !is_nan && (mag[14:7] == 8'hFF);
  assign away = (mode == 3'd0) || (mode == 3'd4) ||
                (mode == 3'd2 && sgn) || (mode == 3'd3 && !sgn);

  assign inc_unb = rnd_up(mode, sgn, frac[15], frac[14], |frac[13:0]);
  assign tiny    = (expo == 8'd0) && !((frac[22:15] == 8'hFF) && inc_unb);

  always_comb begin
    res_c = {sgn, mag[14:0]};
    flg_c = {3'b000, tiny & nx, nx};
    if (illegal) begin
      res_c = '0;
      flg_c = '0;
    end else if (is_nan) begin
      res_c = 16'h7FC0;
      flg_c = {~frac[22], 4'b0000};
    end else if (is_inf) begin
      res_c = {sgn, 15'h7F80};
      flg_c = '0;
    end else if (ovf) begin
      res_c = {sgn, away ? 15'h7F80 : 15'h7F7F};
      flg_c = 5'b00101;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      bad_rm    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_c;
        flags  <= flg_c;
        bad_rm <= illegal;
      end
    end
  end
endmodule

// File: rtl/fp32_to_bf16_cvt_chk.sv
module fp32_to_bf16_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [2:0]  rm_field,
  input logic [2:0]  dyn_rm,
  input logic        out_valid,
  input logic [15:0] result,
  input logic [4:0]  flags,
  input logic        bad_rm
);
  logic legal_in;
  assign legal_in = (rm_field == 3'b111) ? (dyn_rm <= 3'd4) : (rm_field <= 3'd4);

  assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_nan_canon_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !bad_rm && result[14:7] == 8'hFF && result[6:0] != 7'd0) |-> result == 16'h7FC0);
  assert_uf_nx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[1]) |-> flags[0]);
  assert_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flags[2]) |-> (flags[0] && (result[14:0] == 15'h7F80 || result[14:0] == 15'h7F7F)));
  assert_bad_rm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bad_rm) |-> (result == 16'h0000 && flags == 5'd0));
  assert_inf_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal_in && op_a[30:0] == 31'h7F800000) |=>
      (result == {$past(op_a[31]), 15'h7F80} && flags == 5'd0));
  assert_no_dz_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flags[3]);
endmodule

bind fp32_to_bf16_cvt fp32_to_bf16_cvt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
  .rm_field(rm_field), .dyn_rm(dyn_rm), .out_valid(out_valid),
  .result(result), .flags(flags), .bad_rm(bad_rm)
);

// File: tb/sim_fp32_to_bf16_cvt.sv
`timescale 1ns/1ps
module sim_fp32_to_bf16_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [2:0]  rm_field = '0;
  logic [2:0]  dyn_rm = '0;
  logic        out_valid;
  logic [15:0] result;
  logic [4:0]  flags;
  logic        bad_rm;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp32_to_bf16_cvt u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .rm_field(rm_field), .dyn_rm(dyn_rm), .out_valid(out_valid),
    .result(result), .flags(flags), .bad_rm(bad_rm));

  function automatic logic up_rule(input int m, input logic s, input logic above,
                                   input logic tie, input logic odd, input logic nz);
    case (m)
      0: return above | (tie & odd);
      2: return s & nz;
      3: return !s & nz;
      4: return above | tie;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [21:0] model(input logic [31:0] x, input logic [2:0] rf,
                                        input logic [2:0] dr);
    int m;
    logic s, nz, up, ovf, tiny, uf, away;
    logic [7:0] e;
    logic [22:0] f;
    logic [15:0] q, r, mg;
    m = (rf == 3'd7) ? int'(dr) : int'(rf);
    if (m > 4) return {1'b1, 21'd0};
    s = x[31]; e = x[30:23]; f = x[22:0];
    if (e == 8'hFF && f != 0) return {1'b0, f[22] ? 5'b00000 : 5'b10000, 16'h7FC0};
    if (e == 8'hFF) return {6'd0, x[31:16]};
    q = {1'b0, x[30:16]}; r = x[15:0];
    nz = (r != 0);
    up = up_rule(m, s, r > 16'h8000, r == 16'h8000, q[0], nz);
    mg = q + {15'd0, up};
    ovf = mg >= 16'h7F80;
    away = (m == 0) || (m == 4) || (m == 2 && s) || (m == 3 && !s);
    if (ovf) mg = away ? 16'h7F80 : 16'h7F7F;
    tiny = 1'b0;
    if (e == 0 && f != 0) begin
      int p;
      longint kept, rem, half, rounded;
      p = 0;
      for (int i = 0; i < 23; i++) if (f[i]) p = i;
      if (p <= 7) rounded = f;
      else begin
        kept = longint'(f) >> (p - 7);
        rem = longint'(f) & ((64'd1 << (p - 7)) - 1);
        half = 64'd1 << (p - 8);
        rounded = (kept + up_rule(m, s, rem > half, rem == half, kept[0], rem != 0)) << (p - 7);
      end
      tiny = rounded < (64'd1 << 23);
    end
    uf = tiny & nz & !ovf;
    return {1'b0, 1'b0, 1'b0, ovf, uf, nz | ovf, s, mg[14:0]};
  endfunction

  task automatic run(input logic [31:0] x, input logic [2:0] rf, input logic [2:0] dr,
                     input string tag);
    logic [21:0] exp_v;
    exp_v = model(x, rf, dr);
    @(negedge clk);
    op_a = x; rm_field = rf; dyn_rm = dr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || {bad_rm, flags, result} !== exp_v) begin
      fails++;
      $display("FAIL %s op=%h rm=%0d dyn=%0d actual v=%b bad=%b flags=%b res=%h expected bad=%b flags=%b res=%h",
               tag, x, rf, dr, out_valid, bad_rm, flags, result, exp_v[21], exp_v[20:16], exp_v[15:0]);
    end
  endtask

  task automatic expect_out(input logic [15:0] r, input logic [4:0] f, input string tag);
    checks++;
    if (result !== r || flags !== f) begin
      fails++;
      $display("FAIL %s actual res=%h flags=%b expected res=%h flags=%b", tag, result, flags, r, f);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 16'h0 || flags !== 5'h0 || bad_rm !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset actual v=%b res=%h flags=%b bad=%b expected zeros", out_valid, result, flags, bad_rm);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R11 idle actual v=%b expected 0", out_valid);
    end

    run(32'h3F800000, 3'd0, 3'd0, "R1 one");
    expect_out(16'h3F80, 5'b00000, "R1 one literal");
    run(32'h3F808000, 3'd0, 3'd0, "R2 tie even");
    expect_out(16'h3F80, 5'b00001, "R2 tie even literal");
    run(32'h3F818000, 3'd0, 3'd0, "R2 tie odd");
    run(32'h3F808000, 3'd4, 3'd0, "R2 tie away");
    expect_out(16'h3F81, 5'b00001, "R2 tie away literal");
    run(32'hBF808001, 3'd2, 3'd0, "R2 down neg");
    expect_out(16'hBF81, 5'b00001, "R2 down neg literal");
    run(32'hBF80FFFF, 3'd3, 3'd0, "R2 up neg");
    run(32'h3F80FFFF, 3'd1, 3'd0, "R2 zero dir");
    run(32'h3F80FFFF, 3'd7, 3'd1, "R3 dyn rtz");
    expect_out(16'h3F80, 5'b00001, "R3 dyn rtz literal");
    run(32'h3F80FFFF, 3'd7, 3'd3, "R3 dyn up");
    run(32'h3F800001, 3'd5, 3'd0, "R4 field 5");
    run(32'h3F800001, 3'd6, 3'd0, "R4 field 6");
    run(32'h3F800001, 3'd7, 3'd5, "R4 dyn 5");
    expect_out(16'h0000, 5'b00000, "R4 literal");
    run(32'h3F800001, 3'd7, 3'd7, "R4 dyn 7");
    run(32'h00400000, 3'd0, 3'd0, "R5 subnormal exact");
    expect_out(16'h0040, 5'b00000, "R5 literal");
    run(32'h00000001, 3'd3, 3'd0, "R5 tiny up");
    run(32'h7FC00001, 3'd0, 3'd0, "R6 qnan");
    run(32'hFF800001, 3'd0, 3'd0, "R6 snan");
    expect_out(16'h7FC0, 5'b10000, "R6 snan literal");
    run(32'h7F7FFFFF, 3'd0, 3'd0, "R7 ovf rne");
    expect_out(16'h7F80, 5'b00101, "R7 literal");
    run(32'hFF7FFFFF, 3'd2, 3'd0, "R7 ovf rdn");
    run(32'h7F7FFFFF, 3'd1, 3'd0, "R7 no ovf rtz");
    run(32'h007F8000, 3'd0, 3'd0, "R8 carry to normal tiny");
    expect_out(16'h0080, 5'b00011, "R8 literal tiny");
    run(32'h007FFFFF, 3'd0, 3'd0, "R8 carry not tiny");
    expect_out(16'h0080, 5'b00001, "R8 literal not tiny");
    run(32'h007FFFFF, 3'd1, 3'd0, "R8 rtz tiny");
    run(32'h807F8000, 3'd4, 3'd0, "R8 rmm neg");
    run(32'h3F800100, 3'd0, 3'd0, "R9 low sticky");
    run(32'hFF800000, 3'd0, 3'd0, "R10 neg inf");
    run(32'h80000000, 3'd3, 3'd0, "R10 neg zero");
    expect_out(16'h8000, 5'b00000, "R10 literal");

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] x;
      logic [2:0] rf, dr;
      x = $urandom;
      case ($urandom % 6)
        0: x[30:23] = 8'h00;
        1: x[30:23] = 8'h01;
        2: x[30:23] = 8'hFE;
        3: x[30:23] = 8'hFF;
        default: ;
      endcase
      if ($urandom % 4 == 0) x[22:15] = 8'hFF;
      rf = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 5);
      dr = ($urandom % 8 == 0) ? 3'($urandom) : 3'($urandom % 5);
      run(x, rf, dr, "R1 random");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule